// File: doc/BRIEF.md
# DRAM bank timing tracker

This block keeps the timing state of every bank in a DRAM channel with several ranks. A scheduler places one proposed command on the inputs: an operation code, a rank, a bank and a row. In the same cycle the block answers with one legality flag for each command type, all judged for that rank, bank and row. When the command is presented with `cmd_valid` high and its flag is high, the block records it and restarts the countdowns that the command starts. A command presented with its flag low is not recorded and sets a sticky error flag.

Per bank it tracks whether a row is open and which one. It enforces activate-to-column (tRCD), activate-to-precharge (tRAS, three times tRP), precharge-to-activate (tRP) and activate-to-activate (tRC, four times tRP). Per channel it enforces data-bus spacing between column commands and the write/read turnaround penalty, and it shows when read data occupies the bus. Per rank it counts the refresh interval, raises a refresh request, and blocks the rank for the refresh cycle time once the refresh is issued. All timings are given in picoseconds together with the clock period, and are rounded up to whole cycles when the block is elaborated.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset every bank is idle: for any address `act_ok` and `ref_ok` are 1, `rd_ok`, `wr_ok` and `pre_ok` are 0, and `err_flag`, `rdata_valid` and every bit of `refresh_due` are 0. Operation codes on `cmd_op`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh; codes 6 and 7 are always illegal.
- R2: After an activate issued in cycle t, a read or write to that bank and row is legal from cycle t+tRCD and not before (11 cycles by default).
- R3: A read or write is legal only to an open bank whose open row equals `cmd_row`. The same bank with a different row gets 0.
- R4: An activate is legal only to an idle bank. A precharge is legal only to an open bank, from tRAS = 3*tRP cycles after its activate. A new activate to that bank is legal no earlier than tRP after the precharge and no earlier than tRC = 4*tRP after the previous activate (defaults 33, 11 and 44 cycles).
- R5: A read issued in cycle t drives `rdata_valid` high for cycles t+tCL through t+tCL+tBURST-1 (t+11 to t+14 by default). A write never drives it.
- R6: Column commands share one data bus. After a read, the next read is legal from tBURST cycles later and a write from tBURST+tWTR. After a write, the next write is legal from tBURST and a read from tBURST+tWTR (defaults 4 and 10).
- R7: Bit r of `refresh_due` rises tREFI cycles after reset or after the last refresh to rank r (6240 by default). It stays high until a refresh to that rank is issued and is low in the next cycle.
- R8: A refresh is legal only when every bank of the rank is idle and tRP has passed since each bank's last precharge. While a rank's refresh request is high, an activate to that rank is illegal.
- R9: After a refresh to a rank in cycle t, no command to that rank is legal before cycle t+tRFC (240 by default). Other ranks are not affected.
- R10: A command presented with `cmd_valid` high and its legality flag low changes no bank, bus or refresh state. It sets `err_flag` in the next cycle, and `err_flag` then stays high until reset.
- R11: Each timing in cycles is the picosecond value divided by the clock period and rounded up. The defaults are a 1250 ps clock, tRCD, tCL and tRP of 13750 ps, tBURST 5000 ps, tWTR 7500 ps, tRFC 300 ns and tREFI 7.8 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| cmd_valid | input | 1 | Proposed command is issued this cycle if legal |
| cmd_op | input | 3 | Operation code of the proposed command |
| cmd_rank | input | RANK_W | Target rank |
| cmd_bank | input | BANK_W | Target bank within the rank |
| cmd_row | input | ROW_W | Target row |
| act_ok | output | 1 | Activate is legal for the proposed address |
| rd_ok | output | 1 | Read is legal for the proposed address |
| wr_ok | output | 1 | Write is legal for the proposed address |
| pre_ok | output | 1 | Precharge is legal for the proposed address |
| ref_ok | output | 1 | Refresh is legal for the proposed rank |
| rdata_valid | output | 1 | Read data occupies the data bus |
| refresh_due | output | NUM_RANKS | Refresh request, one bit per rank |
| err_flag | output | 1 | Sticky: an illegal command was presented as valid |

## Verification
The assertions check on every cycle the properties that need no knowledge of the timing values: an illegal valid command always raises the error flag and the flag never drops, a read always closes the write window in the next cycle and a write closes the read window, and a refresh request holds until its rank is served and then clears. The exact boundary cycles of tRCD, tRAS, tRP, tRC, the bus spacing, the turnaround, the read-data window, tREFI and tRFC are shown only by the bench scenarios, which probe the flags one cycle before and on the cycle each window opens. The same holds for row matching and for the proof that an illegal command left the bank and bus state alone.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  // Operation codes seen on cmd_op
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } dbt_op_e;

  // Round a picosecond time up to whole clock cycles
  function automatic int dbt_cycles(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int dbt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v
  function automatic int dbt_width(input int v);
    return (v <= 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/dbt_cdown.sv
// Countdown that only ever lengthens: a load keeps the larger of the
// running value and the new one, so independent rules combine safely.
module dbt_cdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d, cnt_dec;

  always_comb begin
    cnt_dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);
    cnt_d   = cnt_dec;
    if (load && (val > cnt_dec)) begin
      cnt_d = val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dbt_bank.sv
// State and timers of one bank: open row plus three countdowns.
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int T_RCD = 11,
  parameter int T_RAS = 33,
  parameter int T_RP  = 11,
  parameter int T_RC  = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_rdy,
  output logic             rw_rdy,
  output logic             pre_rdy
);

  localparam int CW = dbt_width(dbt_max(dbt_max(T_RC, T_RCD), T_RAS));

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;
  logic [CW-1:0]    act_val;

  // Next state of the open flag
  always_comb begin
    open_d = open_q;
    if (do_act) begin
      open_d = 1'b1;
    end else if (do_pre) begin
      open_d = 1'b0;
    end
  end

  assign row_en = do_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_in;
    end
  end

  // Activate gate: row cycle after an activate, precharge time after a precharge
  assign act_val = do_act ? CW'(T_RC - 1) : CW'(T_RP - 1);

  dbt_cdown #(.W(CW)) u_act_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_act | do_pre),
    .val  (act_val),
    .done (act_rdy)
  );

  dbt_cdown #(.W(CW)) u_col_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_act),
    .val  (CW'(T_RCD - 1)),
    .done (rw_rdy)
  );

  dbt_cdown #(.W(CW)) u_pre_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_act),
    .val  (CW'(T_RAS - 1)),
    .done (pre_rdy)
  );

  assign open_o = open_q;
  assign row_o  = row_q;

endmodule

// File: rtl/dbt_bus.sv
// Shared data bus: column spacing, direction turnaround, read data window.
module dbt_bus
  import dbt_pkg::*;
#(
  parameter int T_CL    = 11,
  parameter int T_BURST = 4,
  parameter int T_WTR   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_rd,
  input  logic do_wr,
  output logic rd_rdy,
  output logic wr_rdy,
  output logic rdata_vld
);

  localparam int TW = dbt_width(T_BURST + T_WTR);
  localparam int BW = dbt_width(T_BURST);
  localparam int TA = T_BURST + T_WTR;

  logic [TW-1:0]   rd_val, wr_val;
  logic [T_CL-1:0] pipe_q, pipe_d;
  logic            pipe_top;
  logic            burst_done;

  // Same direction waits one burst, the other direction also the turnaround
  assign rd_val = do_rd ? TW'(T_BURST - 1) : TW'(TA - 1);
  assign wr_val = do_wr ? TW'(T_BURST - 1) : TW'(TA - 1);

  dbt_cdown #(.W(TW)) u_rd_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_rd | do_wr),
    .val  (rd_val),
    .done (rd_rdy)
  );

  dbt_cdown #(.W(TW)) u_wr_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_rd | do_wr),
    .val  (wr_val),
    .done (wr_rdy)
  );

  // Read latency line: a read enters at the bottom, reaches the top after T_CL
  assign pipe_d   = (pipe_q << 1) | T_CL'(do_rd);
  assign pipe_top = pipe_q[T_CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // Remainder of the burst after its first data cycle
  dbt_cdown #(.W(BW)) u_burst (
    .clk  (clk),
    .rst_n(rst_n),
    .load (pipe_top),
    .val  (BW'(T_BURST - 1)),
    .done (burst_done)
  );

  assign rdata_vld = pipe_top | ~burst_done;

endmodule

// File: rtl/dbt_rank.sv
// Refresh interval counter and refresh-cycle blocking for one rank.
module dbt_rank
  import dbt_pkg::*;
#(
  parameter int T_REFI = 6240,
  parameter int T_RFC  = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_ref,
  output logic due_o,
  output logic busy_o
);

  localparam int IW = dbt_width(T_REFI);
  localparam int FW = dbt_width(T_RFC);

  logic [IW-1:0] ivl_q, ivl_d;
  logic          ivl_full;
  logic          rfc_done;

  assign ivl_full = (ivl_q == IW'(T_REFI));

  // Saturating interval counter, cleared by a refresh
  always_comb begin
    ivl_d = ivl_q;
    if (do_ref) begin
      ivl_d = '0;
    end else if (!ivl_full) begin
      ivl_d = ivl_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
    end else begin
      ivl_q <= ivl_d;
    end
  end

  dbt_cdown #(.W(FW)) u_rfc (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_ref),
    .val  (FW'(T_RFC - 1)),
    .done (rfc_done)
  );

  assign due_o  = ivl_full;
  assign busy_o = ~rfc_done;

endmodule

// File: rtl/dram_bank_timer.sv
// Legality tracker for DRAM commands over NUM_RANKS x NUM_BANKS banks.
// NUM_RANKS and NUM_BANKS are powers of two, at least 2.
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int NUM_RANKS  = 2,
  parameter int NUM_BANKS  = 8,
  parameter int ROW_W      = 16,
  parameter int CLK_PS     = 1250,
  parameter int TRCD_PS    = 13750,
  parameter int TCL_PS     = 13750,
  parameter int TRP_PS     = 13750,
  parameter int TBURST_PS  = 5000,
  parameter int TWTR_PS    = 7500,
  parameter int TRFC_PS    = 300000,
  parameter int TREFI_PS   = 7800000,
  parameter int RANK_W     = $clog2(NUM_RANKS),
  parameter int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [RANK_W-1:0]    cmd_rank,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [ROW_W-1:0]     cmd_row,
  output logic                 act_ok,
  output logic                 rd_ok,
  output logic                 wr_ok,
  output logic                 pre_ok,
  output logic                 ref_ok,
  output logic                 rdata_valid,
  output logic [NUM_RANKS-1:0] refresh_due,
  output logic                 err_flag
);

  // Cycle counts rounded up at elaboration
  localparam int T_RCD   = dbt_cycles(TRCD_PS, CLK_PS);
  localparam int T_CL    = dbt_cycles(TCL_PS, CLK_PS);
  localparam int T_RP    = dbt_cycles(TRP_PS, CLK_PS);
  localparam int T_BURST = dbt_cycles(TBURST_PS, CLK_PS);
  localparam int T_WTR   = dbt_cycles(TWTR_PS, CLK_PS);
  localparam int T_RFC   = dbt_cycles(TRFC_PS, CLK_PS);
  localparam int T_REFI  = dbt_cycles(TREFI_PS, CLK_PS);
  localparam int T_RAS   = 3 * T_RP;
  localparam int T_RC    = 4 * T_RP;

  logic             bank_open [NUM_RANKS][NUM_BANKS];
  logic [ROW_W-1:0] bank_row  [NUM_RANKS][NUM_BANKS];
  logic             act_rdy   [NUM_RANKS][NUM_BANKS];
  logic             rw_rdy    [NUM_RANKS][NUM_BANKS];
  logic             pre_rdy   [NUM_RANKS][NUM_BANKS];

  logic [NUM_RANKS-1:0] rank_busy;
  logic [NUM_RANKS-1:0] rank_idle;

  logic             sel_open, sel_act, sel_rw, sel_pre, row_hit;
  logic             rank_free, sel_due, sel_idle;
  logic             bus_rd_rdy, bus_wr_rdy;
  logic             fire_act, fire_rd, fire_wr, fire_pre, fire_ref;
  logic             bad_cmd;
  logic             err_q, err_d, err_en;

  // Selected bank and rank view
  assign sel_open  = bank_open[cmd_rank][cmd_bank];
  assign sel_act   = act_rdy[cmd_rank][cmd_bank];
  assign sel_rw    = rw_rdy[cmd_rank][cmd_bank];
  assign sel_pre   = pre_rdy[cmd_rank][cmd_bank];
  assign row_hit   = (bank_row[cmd_rank][cmd_bank] == cmd_row);
  assign rank_free = ~rank_busy[cmd_rank];
  assign sel_due   = refresh_due[cmd_rank];
  assign sel_idle  = rank_idle[cmd_rank];

  // Legality flags
  assign act_ok = rank_free & ~sel_due & ~sel_open & sel_act;
  assign rd_ok  = rank_free & sel_open & row_hit & sel_rw & bus_rd_rdy;
  assign wr_ok  = rank_free & sel_open & row_hit & sel_rw & bus_wr_rdy;
  assign pre_ok = rank_free & sel_open & sel_pre;
  assign ref_ok = rank_free & sel_idle;

  assign fire_act = cmd_valid & (cmd_op == OP_ACT) & act_ok;
  assign fire_rd  = cmd_valid & (cmd_op == OP_RD)  & rd_ok;
  assign fire_wr  = cmd_valid & (cmd_op == OP_WR)  & wr_ok;
  assign fire_pre = cmd_valid & (cmd_op == OP_PRE) & pre_ok;
  assign fire_ref = cmd_valid & (cmd_op == OP_REF) & ref_ok;

  always_comb begin
    bad_cmd = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_NOP:  bad_cmd = 1'b0;
        OP_ACT:  bad_cmd = ~act_ok;
        OP_RD:   bad_cmd = ~rd_ok;
        OP_WR:   bad_cmd = ~wr_ok;
        OP_PRE:  bad_cmd = ~pre_ok;
        OP_REF:  bad_cmd = ~ref_ok;
        default: bad_cmd = 1'b1;
      endcase
    end
  end

  // A rank may refresh once all its banks are closed and precharged
  always_comb begin
    for (int r = 0; r < NUM_RANKS; r++) begin
      rank_idle[r] = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_open[r][b] || !act_rdy[r][b]) begin
          rank_idle[r] = 1'b0;
        end
      end
    end
  end

  // Bank array and per-rank refresh
  for (genvar gr = 0; gr < NUM_RANKS; gr++) begin : g_rank
    logic rank_hit;
    assign rank_hit = (cmd_rank == RANK_W'(gr));

    dbt_rank #(
      .T_REFI(T_REFI),
      .T_RFC (T_RFC)
    ) u_rank (
      .clk   (clk),
      .rst_n (rst_n),
      .do_ref(fire_ref & rank_hit),
      .due_o (refresh_due[gr]),
      .busy_o(rank_busy[gr])
    );

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic bank_hit;
      assign bank_hit = rank_hit & (cmd_bank == BANK_W'(gb));

      dbt_bank #(
        .ROW_W(ROW_W),
        .T_RCD(T_RCD),
        .T_RAS(T_RAS),
        .T_RP (T_RP),
        .T_RC (T_RC)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_act (fire_act & bank_hit),
        .do_pre (fire_pre & bank_hit),
        .row_in (cmd_row),
        .open_o (bank_open[gr][gb]),
        .row_o  (bank_row[gr][gb]),
        .act_rdy(act_rdy[gr][gb]),
        .rw_rdy (rw_rdy[gr][gb]),
        .pre_rdy(pre_rdy[gr][gb])
      );
    end
  end

  dbt_bus #(
    .T_CL   (T_CL),
    .T_BURST(T_BURST),
    .T_WTR  (T_WTR)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_rd    (fire_rd),
    .do_wr    (fire_wr),
    .rd_rdy   (bus_rd_rdy),
    .wr_rdy   (bus_wr_rdy),
    .rdata_vld(rdata_valid)
  );

  // Sticky error flag
  assign err_en = bad_cmd;
  assign err_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_flag = err_q;

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NUM_RANKS = 2,
  parameter int RANK_W    = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [RANK_W-1:0]    cmd_rank,
  input logic                 act_ok,
  input logic                 rd_ok,
  input logic                 wr_ok,
  input logic                 pre_ok,
  input logic                 ref_ok,
  input logic                 err_flag,
  input logic [NUM_RANKS-1:0] refresh_due
);

  logic illegal_cmd, rd_go, wr_go, ref_go;

  assign illegal_cmd = cmd_valid &&
                       (((cmd_op == 3'd1) && !act_ok) ||
                        ((cmd_op == 3'd2) && !rd_ok)  ||
                        ((cmd_op == 3'd3) && !wr_ok)  ||
                        ((cmd_op == 3'd4) && !pre_ok) ||
                        ((cmd_op == 3'd5) && !ref_ok) ||
                        (cmd_op > 3'd5));
  assign rd_go  = cmd_valid && (cmd_op == 3'd2) && rd_ok;
  assign wr_go  = cmd_valid && (cmd_op == 3'd3) && wr_ok;
  assign ref_go = cmd_valid && (cmd_op == 3'd5) && ref_ok;

  assert_illegal_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |=> err_flag);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_read_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !wr_ok);

  assert_write_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !rd_ok);

  assert_refresh_clears_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |=> !refresh_due[$past(cmd_rank)]);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_due
    assert_due_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_due[r] && !(ref_go && (cmd_rank == RANK_W'(r)))) |=> refresh_due[r]);
  end

endmodule

bind dram_bank_timer dbt_checker #(
  .NUM_RANKS(NUM_RANKS),
  .RANK_W   (RANK_W)
) u_chk (.*);

// File: tb/sim_dram_bank_timer.sv
`timescale 1ns/1ps
module sim_dram_bank_timer;

  // Cycle counts for the default parameters, derived here (R11)
  localparam int P_CLK  = 1250;
  localparam int E_REFI = (7800000 + P_CLK - 1) / P_CLK;  // 6240
  localparam int E_RFC  = (300000 + P_CLK - 1) / P_CLK;   // 240

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [0:0]  cmd_rank;
  logic [2:0]  cmd_bank;
  logic [15:0] cmd_row;
  logic        act_ok, rd_ok, wr_ok, pre_ok, ref_ok, rdata_valid, err_flag;
  logic [1:0]  refresh_due;

  dram_bank_timer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok),
    .ref_ok(ref_ok), .rdata_valid(rdata_valid), .refresh_due(refresh_due),
    .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    fld;
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   edges = 0;
  bit   ended = 1'b0;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic bit field(int f);
    case (f)
      0: return act_ok;
      1: return rd_ok;
      2: return wr_ok;
      3: return pre_ok;
      4: return ref_ok;
      5: return err_flag;
      6: return rdata_valid;
      7: return refresh_due[0];
      default: return refresh_due[1];
    endcase
  endfunction

  function automatic string fname(int f);
    case (f)
      0: return "act_ok";
      1: return "rd_ok";
      2: return "wr_ok";
      3: return "pre_ok";
      4: return "ref_ok";
      5: return "err_flag";
      6: return "rdata_valid";
      7: return "refresh_due[0]";
      default: return "refresh_due[1]";
    endcase
  endfunction

  // Monitor: compares queued expectations in the middle of the low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_chk++;
        if (field(it.fld) !== it.val) begin
          n_fail++;
          $display("FAIL %s: %s actual %0b expected %0b at edge %0d",
                   it.tag, fname(it.fld), field(it.fld), it.val, edges);
        end
      end
    end
  end

  // Driver: presents one command per cycle just after the falling edge
  task automatic go(bit v, logic [2:0] op, int r, int b, int row);
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    cmd_rank  = 1'(r);
    cmd_bank  = 3'(b);
    cmd_row   = 16'(row);
  endtask

  task automatic probe(int r, int b, int row);
    go(1'b0, 3'd0, r, b, row);
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) go(1'b0, 3'd0, cmd_rank, cmd_bank, cmd_row);
  endtask

  task automatic chk(int f, bit v, string tag);
    q.push_back('{fld: f, val: v, tag: tag});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL all: watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_rank = '0; cmd_bank = '0; cmd_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    probe(0, 0, 5);
    chk(0, 1, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, 0, "R1");
    chk(4, 1, "R1"); chk(5, 0, "R1"); chk(6, 0, "R1"); chk(7, 0, "R1"); chk(8, 0, "R1");

    // R2/R3/R4: activate rank0 bank0 row5 in cycle c
    go(1'b1, 3'd1, 0, 0, 5);
    hold(9);
    probe(0, 0, 5);                                  // c+10
    chk(1, 0, "R2"); chk(2, 0, "R2");
    probe(0, 0, 5);                                  // c+11
    chk(1, 1, "R2"); chk(2, 1, "R2");
    probe(0, 0, 6);                                  // c+12, other row
    chk(1, 0, "R3"); chk(2, 0, "R3"); chk(0, 0, "R4"); chk(3, 0, "R4");
    probe(0, 0, 5);                                  // c+13
    chk(4, 0, "R8");

    // R5/R6: read in cycle d
    go(1'b1, 3'd2, 0, 0, 5);
    probe(0, 0, 5); chk(1, 0, "R6");                 // d+1
    hold(1);                                         // d+2
    probe(0, 0, 5); chk(1, 0, "R6");                 // d+3
    probe(0, 0, 5); chk(1, 1, "R6");                 // d+4
    hold(4);                                         // d+5..d+8
    probe(0, 0, 5); chk(2, 0, "R6");                 // d+9
    probe(0, 0, 5); chk(2, 1, "R6"); chk(6, 0, "R5"); // d+10
    probe(0, 0, 5); chk(6, 1, "R5");                 // d+11
    hold(2);                                         // d+12, d+13
    probe(0, 0, 5); chk(6, 1, "R5");                 // d+14
    probe(0, 0, 5); chk(6, 0, "R5");                 // d+15

    // R6: write in cycle e
    go(1'b1, 3'd3, 0, 0, 5);
    hold(2);                                         // e+1, e+2
    probe(0, 0, 5); chk(2, 0, "R6");                 // e+3
    probe(0, 0, 5); chk(2, 1, "R6");                 // e+4
    hold(4);                                         // e+5..e+8
    probe(0, 0, 5); chk(1, 0, "R6");                 // e+9
    probe(0, 0, 5); chk(1, 1, "R6");                 // e+10
    probe(0, 0, 5); chk(6, 0, "R5"); chk(3, 1, "R4"); // e+11

    // R4: precharge bank0 in cycle p, reopen after tRP
    go(1'b1, 3'd4, 0, 0, 5);
    hold(9);
    probe(0, 0, 5); chk(0, 0, "R4"); chk(1, 0, "R4"); // p+10
    probe(0, 0, 5); chk(0, 1, "R4");                 // p+11

    // R4/R8: activate bank1 in cycle a, precharge at a+33
    go(1'b1, 3'd1, 0, 1, 7);
    probe(0, 1, 7); chk(4, 0, "R8"); chk(3, 0, "R4"); // a+1
    hold(30);                                        // a+2..a+31
    probe(0, 1, 7); chk(3, 0, "R4");                 // a+32
    go(1'b1, 3'd4, 0, 1, 7); chk(3, 1, "R4");        // a+33
    hold(9);                                         // a+34..a+42
    probe(0, 1, 7); chk(0, 0, "R4"); chk(4, 0, "R8"); // a+43
    probe(0, 1, 7); chk(0, 1, "R4"); chk(4, 1, "R8"); // a+44

    // R10: read to an idle bank is refused and leaves no trace
    go(1'b1, 3'd2, 0, 3, 0); chk(1, 0, "R10"); chk(5, 0, "R10");
    probe(0, 3, 0);
    chk(5, 1, "R10"); chk(0, 1, "R10"); chk(1, 0, "R10");
    probe(0, 0, 0);  chk(5, 1, "R10");
    hold(9);
    probe(0, 3, 0);  chk(6, 0, "R10"); chk(5, 1, "R10");

    // R7/R8: wait for the refresh interval
    do go(1'b0, 3'd0, 0, 5, 0); while (edges < E_REFI - 1);
    chk(7, 0, "R7"); chk(8, 0, "R7");
    probe(0, 5, 0);
    chk(7, 1, "R7"); chk(8, 1, "R7"); chk(0, 0, "R8"); chk(4, 1, "R8");
    hold(3);
    chk(7, 1, "R7");

    // R9: refresh rank0 in cycle f, rank1 in f+1
    go(1'b1, 3'd5, 0, 5, 0); chk(4, 1, "R9");
    go(1'b1, 3'd5, 1, 0, 0);
    chk(7, 0, "R7"); chk(8, 1, "R7"); chk(4, 1, "R9"); chk(0, 0, "R8");
    probe(0, 0, 0);                                  // f+2
    chk(0, 0, "R9"); chk(4, 0, "R9"); chk(7, 0, "R7"); chk(8, 0, "R7");
    hold(E_RFC - 4);                                 // f+3..f+238
    probe(0, 0, 0); chk(0, 0, "R9");                 // f+239
    probe(0, 0, 0); chk(0, 1, "R9"); chk(4, 1, "R9"); // f+240
    probe(1, 0, 0); chk(0, 1, "R9");                 // f+241

    hold(2);
    @(negedge clk);
    #2;
    if (!ended) begin
      ended = 1'b1;
      summary();
      $finish;
    end
  end

endmodule